// File: doc/BRIEF.md
# Serial 01 Sequence Detector, Moore and Mealy Pair

The block watches a single serial data line that carries one bit per clock. It raises a flag whenever the two most recent bits were a 0 followed by a 1. The block contains two versions of this detector, and both see the same input stream.

The Moore version keeps a two-bit state. Its flag comes only from that state, so the flag is registered and appears one clock after the matching 1. The Mealy version keeps a single history bit. It combines that bit with the live input, so its flag appears during the same cycle as the matching 1.

A designer can pick whichever timing fits the logic downstream, or use the pair as a reference for the one-cycle offset. Matches may overlap: the stream 0101 gives two flags from each version.

Top module: `pattern01_detect`

## Requirements
- R1: While `rst_n` is low, both `y_moore` and `y_mealy` are 0, whatever the value of `a`. Reset is asynchronous, is active low, and is released on the falling clock edge.
- R2: `y_mealy` is 1 in a cycle exactly when the present `a` is 1 and the `a` sampled at the previous rising edge was 0.
- R3: `y_moore` is 1 in the cycle after a rising edge that sampled `a`=1, provided the edge before that one sampled `a`=0. Otherwise it is 0.
- R4: The Moore state uses these codes: 00 means no useful history, 01 means the last bit was 0, and 10 means 0 then 1 was just seen. The next high bit is the low bit AND `a`, the next low bit is NOT `a`, and `y_moore` is the high bit. Code 11 never occurs.
- R5: Overlapping matches are all reported. The input 0101 gives two `y_mealy` pulses and two `y_moore` pulses.
- R6: After reset, neither output is 1 until at least two bits have been sampled. The bit present in the first cycle after reset can never produce a flag.
- R7: Outside reset, `y_moore` always equals the value `y_mealy` had in the previous cycle.
- R8: Reset in the middle of a stream erases all history. If the stream ends in a 0 and a 1 follows reset, no flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a | input | 1 | Serial data bit, one per clock |
| y_moore | output | 1 | Registered match flag, one cycle after the matching 1 |
| y_mealy | output | 1 | Combinational match flag, in the same cycle as the matching 1 |

## Verification
Every 8-bit word is fed in from a clean reset, followed by a flush bit. This tries runs of zeros, runs of ones, alternating bits and each position of a match. Each cycle is compared against a model of the previous bit and one cycle of delay. Per-word pulse totals are checked against an arithmetic count of 01 pairs, which separates correct overlap handling from detectors that skip a match. A long stream from a linear feedback shift register tests the one-cycle lag over many state paths. A reset taken right after a 0 shows whether stale history survives reset.

// File: rtl/det01_pkg.sv
package det01_pkg;

  typedef enum logic [1:0] {
    MS_IDLE = 2'b00,
    MS_ZERO = 2'b01,
    MS_HIT  = 2'b10
  } moore_st_e;

endpackage

// File: rtl/det01_moore.sv
module det01_moore
  import det01_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic a,
  output logic y
);

  moore_st_e state_q, state_d;

  always_comb begin
    state_d = moore_st_e'({state_q[0] & a, ~a});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= MS_IDLE;
    else        state_q <= state_d;
  end

  assign y = state_q[1];

  p_moore_enc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != 2'b11)
    else $error("R4: illegal Moore state code");

  p_moore_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MS_ZERO && a) |=> y)
    else $error("R3: Moore flag missing after 0 then 1");

  p_moore_nohit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !a |=> !y)
    else $error("R3: Moore flag after a 0 bit");

endmodule

// File: rtl/det01_mealy.sv
module det01_mealy (
  input  logic clk,
  input  logic rst_n,
  input  logic a,
  output logic y
);

  logic last0_q, last0_d;

  always_comb begin
    last0_d = ~a;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last0_q <= 1'b0;
    else        last0_q <= last0_d;
  end

  assign y = last0_q & a;

  p_mealy_needs_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    y |-> a)
    else $error("R2: Mealy flag without a 1 input");

  p_mealy_after_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!a ##1 a) |-> y)
    else $error("R2: Mealy flag missing on 0 then 1");

endmodule

// File: rtl/pattern01_detect.sv
module pattern01_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic a,
  output logic y_moore,
  output logic y_mealy
);

  det01_moore u_moore (
    .clk   (clk),
    .rst_n (rst_n),
    .a     (a),
    .y     (y_moore)
  );

  det01_mealy u_mealy (
    .clk   (clk),
    .rst_n (rst_n),
    .a     (a),
    .y     (y_mealy)
  );

  p_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    y_moore == $past(y_mealy))
    else $error("R7: Moore flag is not the Mealy flag delayed one cycle");

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!y_moore && !y_mealy))
    else $error("R1: flag high during reset");

endmodule

// File: tb/pattern01_detect_test.sv
`timescale 1ns/1ps
module pattern01_detect_test;

  logic clk = 1'b0;
  logic rst_n;
  logic a;
  logic y_moore, y_mealy;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model
  bit m_last0;
  bit m_moore;
  int cnt_mealy, cnt_moore;

  always #2 clk = ~clk;

  pattern01_detect uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .a       (a),
    .y_moore (y_moore),
    .y_mealy (y_mealy)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    a = 1'b1;
    #1;
    check("R1 mealy in reset", y_mealy, 1'b0);
    check("R1 moore in reset", y_moore, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    m_last0 = 1'b0;
    m_moore = 1'b0;
  endtask

  task automatic step(input bit b, input string tag);
    bit e_mealy;
    @(negedge clk);
    a = b;
    #1;
    e_mealy = m_last0 & b;
    check({tag, " R2 mealy"}, y_mealy, e_mealy);
    check({tag, " R3 R4 R7 moore"}, y_moore, m_moore);
    if (y_mealy) cnt_mealy++;
    if (y_moore) cnt_moore++;
    m_moore = e_mealy;
    m_last0 = ~b;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    a = 1'b0;
    do_reset();

    // exhaustive 8-bit words, MSB first, then a flush bit
    for (int v = 0; v < 256; v++) begin
      int exp_pairs;
      do_reset();
      cnt_mealy = 0;
      cnt_moore = 0;
      exp_pairs = 0;
      for (int i = 7; i > 0; i--)
        if (!v[i] && v[i-1]) exp_pairs++;
      // R6: the first bit after reset never flags
      @(negedge clk);
      a = v[7];
      #1;
      check("R6 mealy first bit", y_mealy, 1'b0);
      check("R6 moore first bit", y_moore, 1'b0);
      if (y_mealy) cnt_mealy++;
      if (y_moore) cnt_moore++;
      m_moore = 1'b0;
      m_last0 = ~v[7];
      for (int i = 6; i >= 0; i--) step(v[i], "sweep");
      step(1'b0, "flush");
      check("R5 mealy pulse count", (cnt_mealy == exp_pairs), 1'b1);
      check("R5 moore pulse count", (cnt_moore == exp_pairs), 1'b1);
    end

    // explicit overlap case 0101
    do_reset();
    cnt_mealy = 0;
    cnt_moore = 0;
    step(1'b0, "R5"); step(1'b1, "R5"); step(1'b0, "R5"); step(1'b1, "R5");
    step(1'b0, "R5");
    check("R5 0101 mealy two pulses", (cnt_mealy == 2), 1'b1);
    check("R5 0101 moore two pulses", (cnt_moore == 2), 1'b1);

    // long pseudo-random stream
    begin
      logic [15:0] lfsr = 16'hACE1;
      do_reset();
      for (int k = 0; k < 3000; k++) begin
        step(lfsr[0], "R7 lfsr");
        lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
      end
    end

    // R8: reset right after a 0 erases history
    do_reset();
    step(1'b1, "R8"); step(1'b0, "R8");
    do_reset();
    @(negedge clk);
    a = 1'b1;
    #1;
    check("R8 mealy after mid-stream reset", y_mealy, 1'b0);
    @(negedge clk);
    a = 1'b0;
    #1;
    check("R8 moore after mid-stream reset", y_moore, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule